// File: doc/BRIEF.md
# Predicated Vector Absolute Max/Min Unit

This block updates a 128-bit destination vector lane by lane. Each lane of the source vector is read as a signed integer and replaced by its magnitude. That magnitude is compared, as an unsigned number, with the matching destination lane. The larger or the smaller of the two becomes the lane result, depending on the operation select. The lane width is chosen per operation: 8, 16 or 32 bits, which gives 16, 8 or 4 lanes.

The computed vector is merged into the old destination one byte at a time, under a 16-bit predicate that has one bit per byte. The merged vector is registered. It appears on the output one clock after the valid strobe, and the output register keeps its value until the next strobe. The surrounding pipeline supplies the operands and the predicate, and it writes the result back into its register file.

Top module: `vabs_minmax_unit`

## Requirements
- R1: While `rst_n` is low, `res_vec` and `out_valid` read zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and in that cycle `res_vec` carries the result for the operands sampled with the strobe.
- R3: Each source lane is read as two's complement and its magnitude is used without saturation. The most negative value maps to 2^(W-1), so byte 0x80 becomes 128.
- R4: Destination lanes are unsigned, and the comparison against the magnitude is unsigned. For example, byte 0xF0 (240) is larger than a magnitude of 100.
- R5: `op_min` = 0 selects the unsigned maximum of magnitude and destination. `op_min` = 1 selects the unsigned minimum.
- R6: `size_sel` 00 gives byte lanes at bits [8e+7:8e], 01 gives halfword lanes at bits [16e+15:16e], and 10 gives word lanes at bits [32e+31:32e].
- R7: `size_sel` 11 is reserved. The result then equals the destination vector unchanged.
- R8: Bit b of `pred_mask` governs result bits [8b+7:8b]. Where the bit is clear, the result byte equals the destination byte. Where it is set, the result byte is the computed byte. A lane of E bytes therefore uses mask bits E·e upward.
- R9: In a cycle with `in_valid` low, `res_vec` keeps its previous value at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands are valid this cycle |
| size_sel | input | 2 | Lane size: 00 byte, 01 halfword, 10 word, 11 reserved |
| op_min | input | 1 | 0 = maximum, 1 = minimum |
| pred_mask | input | 16 | One write-enable bit per byte |
| src_vec | input | 128 | Signed source lanes |
| dst_vec | input | 128 | Unsigned current destination lanes |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_vec | output | 128 | Registered merged result |

## Verification
The only state is the output register and its valid flag. A corrupt lane computation or a mis-sliced predicate shows up in `res_vec` on the edge right after the strobe, with no latency to hide it. A lost hold shows as a changed `res_vec` in the first idle cycle. The directed tests therefore compare every strobe's result one edge later against a model built from the requirements. They also place edge values (0x80, 0x8000, 0x80000000, unsigned destinations above the magnitude) in chosen lanes so that slicing faults move bytes visibly.

// File: rtl/vamm_pkg.sv
package vamm_pkg;
  localparam int VEC_BYTES = 16;
  localparam int VEC_W     = VEC_BYTES * 8;
  localparam int NUM_SIZES = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } lane_size_e;
endpackage

// File: rtl/vamm_lane.sv
module vamm_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         op_min_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] mag;
  logic         mag_gt;

  always_comb begin
    mag    = src_i[W-1] ? (~src_i + 1'b1) : src_i;
    mag_gt = (mag > dst_i);
    if (op_min_i) res_o = mag_gt ? dst_i : mag;
    else          res_o = mag_gt ? mag : dst_i;
  end

  // R5: max never below destination, min never above it
  always_comb begin
    if (!$isunknown({src_i, dst_i, op_min_i})) begin
      p_order_r5: assert (op_min_i ? (res_o <= dst_i) : (res_o >= dst_i));
    end
  end
endmodule

// File: rtl/vamm_merge.sv
module vamm_merge #(
  parameter int NBYTES = 16
) (
  input  logic [NBYTES*8-1:0] calc_i,
  input  logic [NBYTES*8-1:0] dst_i,
  input  logic [NBYTES-1:0]   pred_i,
  output logic [NBYTES*8-1:0] merged_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged_o[b*8 +: 8] = pred_i[b] ? calc_i[b*8 +: 8] : dst_i[b*8 +: 8];
  end
endmodule

// File: rtl/vabs_minmax_unit.sv
module vabs_minmax_unit
  import vamm_pkg::*;
#(
  parameter int NBYTES = VEC_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          size_sel,
  input  logic                op_min,
  input  logic [NBYTES-1:0]   pred_mask,
  input  logic [NBYTES*8-1:0] src_vec,
  input  logic [NBYTES*8-1:0] dst_vec,
  output logic                out_valid,
  output logic [NBYTES*8-1:0] res_vec
);
  localparam int VW = NBYTES * 8;

  logic [NUM_SIZES-1:0][VW-1:0] calc;
  logic [VW-1:0] calc_sel;
  logic [VW-1:0] merged;
  logic [VW-1:0] res_d, res_q;
  logic          vld_q;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int ESZ   = 1 << g;
    localparam int W     = 8 * ESZ;
    localparam int LANES = NBYTES / ESZ;
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      vamm_lane #(.W(W)) u_lane (
        .src_i    (src_vec[e*W +: W]),
        .dst_i    (dst_vec[e*W +: W]),
        .op_min_i (op_min),
        .res_o    (calc[g][e*W +: W])
      );
    end
  end

  always_comb begin
    unique case (lane_size_e'(size_sel))
      SZ_BYTE: calc_sel = calc[0];
      SZ_HALF: calc_sel = calc[1];
      SZ_WORD: calc_sel = calc[2];
      default: calc_sel = dst_vec;
    endcase
  end

  vamm_merge #(.NBYTES(NBYTES)) u_merge (
    .calc_i   (calc_sel),
    .dst_i    (dst_vec),
    .pred_i   (pred_mask),
    .merged_o (merged)
  );

  always_comb begin
    res_d = res_q;
    if (in_valid) res_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign res_vec   = res_q;
  assign out_valid = vld_q;

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_vec));
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b11) |=> (res_vec == $past(dst_vec)));
  p_no_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_mask == '0) |=> (res_vec == $past(dst_vec)));
endmodule

// File: tb/vabs_minmax_unit_tb.sv
module vabs_minmax_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   size_sel = 2'b00;
  logic         op_min = 1'b0;
  logic [15:0]  pred_mask = '0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic         out_valid;
  logic [127:0] res_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vabs_minmax_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .op_min(op_min), .pred_mask(pred_mask), .src_vec(src_vec),
    .dst_vec(dst_vec), .out_valid(out_valid), .res_vec(res_vec)
  );

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic [1:0] sz, input logic mn,
                                         input logic [15:0] p);
    logic [127:0] c;
    c = d;
    if (sz != 2'b11) begin
      int esz = 1 << sz;
      int w = 8 * esz;
      for (int e = 0; e < 16 / esz; e++) begin
        logic [32:0] a, dv, m, r;
        a = '0; dv = '0;
        for (int k = 0; k < w; k++) begin
          a[k]  = s[e*w + k];
          dv[k] = d[e*w + k];
        end
        m = a[w-1] ? ((33'd1 << w) - a) : a;
        if (mn) r = (m < dv) ? m : dv;
        else    r = (m > dv) ? m : dv;
        for (int k = 0; k < w; k++) c[e*w + k] = r[k];
      end
    end
    for (int b = 0; b < 16; b++)
      if (!p[b]) c[b*8 +: 8] = d[b*8 +: 8];
    return c;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, sample one edge later
  task automatic run_op(input string req, input logic [127:0] s, input logic [127:0] d,
                        input logic [1:0] sz, input logic mn, input logic [15:0] p);
    @(negedge clk);
    src_vec = s; dst_vec = d; size_sel = sz; op_min = mn; pred_mask = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, {127'd0, out_valid}, 128'd1);
    check(req, res_vec, model(s, d, sz, mn, p));
  endtask

  task automatic t_reset;
    check("R1 res", res_vec, '0);
    check("R1 valid", {127'd0, out_valid}, '0);
  endtask

  task automatic t_byte_edges;
    logic [127:0] s, d;
    s = {8'h80, 8'h7F, 8'hFF, 8'h01, 8'h9C, 8'h64, 8'h00, 8'h81,
         8'h80, 8'h80, 8'hF6, 8'h0A, 8'hC0, 8'h40, 8'hFE, 8'h02};
    d = {8'h00, 8'h10, 8'h00, 8'hFF, 8'hF0, 8'h05, 8'h00, 8'h7E,
         8'hFF, 8'h7F, 8'h0A, 8'h0B, 8'h41, 8'h3F, 8'h02, 8'h03};
    run_op("R3 R4 R6 byte max", s, d, 2'b00, 1'b0, 16'hFFFF);
    check("R3 min neg byte", {120'd0, res_vec[127:120]}, 128'h80);
    run_op("R5 byte min", s, d, 2'b00, 1'b1, 16'hFFFF);
    check("R4 unsigned dst", {120'd0, res_vec[95:88]}, 128'h64);
  endtask

  task automatic t_half_word;
    logic [127:0] s, d;
    s = 128'h8000_7FFF_FF00_0100_8001_1234_EDCC_0080;
    d = 128'h0001_8000_00FF_FFFF_7FFF_1233_1234_FF00;
    run_op("R6 half max", s, d, 2'b01, 1'b0, 16'hFFFF);
    check("R3 half min neg", {112'd0, res_vec[127:112]}, 128'h8000);
    run_op("R6 half min", s, d, 2'b01, 1'b1, 16'hFFFF);
    s = 128'h8000_0000_FFFF_FFFF_0000_0100_8000_0001;
    d = 128'h7FFF_FFFF_0000_0000_0000_00FF_FFFF_FFFF;
    run_op("R6 word max", s, d, 2'b10, 1'b0, 16'hFFFF);
    check("R3 word min neg", {96'd0, res_vec[127:96]}, 128'h8000_0000);
    run_op("R6 word min", s, d, 2'b10, 1'b1, 16'hFFFF);
  endtask

  task automatic t_reserved;
    run_op("R7 reserved", {16{8'h85}}, {8{16'hA5A5}}, 2'b11, 1'b0, 16'hFFFF);
    check("R7 reserved eq dst", res_vec, {8{16'hA5A5}});
  endtask

  task automatic t_predicate;
    logic [127:0] s, d;
    s = {16{8'hC8}};
    d = {16{8'h11}};
    run_op("R8 byte pred", s, d, 2'b00, 1'b0, 16'hA5C3);
    run_op("R8 word pred", s, d, 2'b10, 1'b0, 16'h0F30);
    run_op("R8 pred none", s, d, 2'b01, 1'b0, 16'h0000);
    check("R8 none eq dst", res_vec, d);
  endtask

  task automatic t_hold;
    logic [127:0] snap;
    snap = res_vec;
    @(negedge clk);
    src_vec = '1; dst_vec = '0; pred_mask = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold", res_vec, snap);
    check("R2 idle valid", {127'd0, out_valid}, '0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_edges();
    t_half_word();
    t_reserved();
    t_predicate();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule